// File: doc/BRIEF.md
# DRAM Error Address Normalizer

This block converts an encoded DRAM error address, as reported by a memory controller back end, into the normalized address that later system address translation expects. The 28-bit encoded address packs a stack selector, a pseudo-channel bit, a 14-bit row, a six-bit bank and a 5-bit column. The memory controller scrambles four bank bits and the pseudo-channel bit with XOR hashes. The block recovers these bits by recomputing the same masked parities from the programmed hash settings. It then places every surviving bit at its normalized position through a fixed permutation that is not monotonic.

Software loads six hash words through a small write port: four bank-hash words, one pseudo-channel hash word and one pseudo-channel bank mask. Each encoded address is presented with a valid strobe. One cycle later the normalized address appears on registered outputs, together with the recovered bank, row and column for debug.

Top module: `dram_addr_normalizer`

## Requirements
- R1: After reset, out_valid_o is 0 and every hash word is zero, so no hashing is applied: a converted address equals the plain bit permutation of the input.
- R2: out_col_o equals input bits [5:1] and out_row_o equals input bits [23:10] of the converted input.
- R3: Write address k (0..3) loads bank-hash word k: bit 0 enables it, bits [5:1] mask the column bits, bits [27:14] mask the row bits, and the other bits are ignored. Recovered bank bit k is input bit 6+k XOR (enable AND (parity of column&mask XOR parity of row&mask)).
- R4: out_bank_o is the six-bit bank made of the four recovered bank bits in [3:0], with input bits 26 and 27 in [5:4].
- R5: Write address 4 loads the pseudo-channel word (same layout as R3). Write address 5 loads a bank mask from bits [5:0]. The recovered pseudo-channel bit is input bit 25 XOR (enable AND (column parity XOR row parity XOR parity of out_bank_o&bank mask)).
- R6: With the recovered bank bits in positions [9:6] and the recovered pseudo-channel bit in position 25, input bit i (1..26) goes to output bit p(i), where p(1..9) = 5,6,8,9,14,12,13,10,11, p(i) = i+5 for i = 10..23, and p(24..26) = 7,29,30.
- R7: Output bits [4:0] are always zero. Input bits 0 and 27 never reach out_addr_o.
- R8: out_valid_o is 1 in exactly the cycle after an accepted in_valid_i and 0 otherwise. The data outputs change only when a conversion completes.
- R9: A write made in the same cycle as an accepted input does not affect that input. It does apply to the next input.
- R10: Writes to addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Hash word write strobe |
| cfg_addr_i | input | 3 | Hash word select (0..3 bank, 4 pseudo-channel, 5 bank mask) |
| cfg_wdata_i | input | 32 | Hash word write data |
| in_valid_i | input | 1 | Encoded address valid |
| in_addr_i | input | 28 | Encoded DRAM error address |
| out_valid_o | output | 1 | Normalized result valid |
| out_addr_o | output | 31 | Normalized address |
| out_bank_o | output | 6 | Recovered bank |
| out_row_o | output | 14 | Row field |
| out_col_o | output | 5 | Column field |

## Verification
The hash-word write path and the conversion path can act in the same cycle. This matters because the recovered bits read the stored words combinationally. The bench places writes alongside valid inputs, at random and in directed cases that turn hashing on or change its masks. It predicts each such input with the hash model as it stood before the write, then checks that the following input sees the new words. Masks that touch only the upper bank bits are used as well, so that a pseudo-channel result that depends on the bank mask is shown to respond to input bit 27.

// File: rtl/dram_norm_pkg.sv
package dram_norm_pkg;
  localparam int ENC_W     = 28;
  localparam int NORM_W    = 31;
  localparam int COL_W     = 5;
  localparam int ROW_W     = 14;
  localparam int HBANK_N   = 4;
  localparam int BANK_W    = 6;
  localparam int CFG_W     = 32;
  localparam int CFG_AW    = 3;

  localparam int COL_LSB   = 1;
  localparam int BANK_LSB  = 6;
  localparam int ROW_LSB   = 10;
  localparam int PC_POS    = 25;
  localparam int BHI_LSB   = 26;
  localparam int CMASK_LSB = 1;
  localparam int RMASK_LSB = 14;

  localparam int CFG_PC    = HBANK_N;
  localparam int CFG_PCB   = HBANK_N + 1;

  typedef struct packed {
    logic             en;
    logic [COL_W-1:0] cmask;
    logic [ROW_W-1:0] rmask;
  } hash_cfg_t;

  function automatic hash_cfg_t unpack_hash(logic [CFG_W-1:0] w);
    hash_cfg_t c;
    c.en    = w[0];
    c.cmask = w[CMASK_LSB +: COL_W];
    c.rmask = w[RMASK_LSB +: ROW_W];
    return c;
  endfunction

  function automatic logic hash_term(hash_cfg_t c, logic [COL_W-1:0] col,
                                     logic [ROW_W-1:0] row);
    return c.en & ((^(col & c.cmask)) ^ (^(row & c.rmask)));
  endfunction

  // normalized position of fixed encoded bit i (valid for 1..ENC_W-2)
  function automatic int norm_pos(int i);
    case (i)
      1:  return 5;
      2:  return 6;
      3:  return 8;
      4:  return 9;
      5:  return 14;
      6:  return 12;
      7:  return 13;
      8:  return 10;
      9:  return 11;
      24: return 7;
      25: return 29;
      26: return 30;
      default: return i + 5;
    endcase
  endfunction
endpackage

// File: rtl/dram_norm_cfg.sv
module dram_norm_cfg
  import dram_norm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  output hash_cfg_t         bank_cfg_o [HBANK_N],
  output hash_cfg_t         pc_cfg_o,
  output logic [BANK_W-1:0] pc_bmask_o
);
  hash_cfg_t         bank_q [HBANK_N];
  hash_cfg_t         pc_q;
  logic [BANK_W-1:0] bmask_q;

  for (genvar k = 0; k < HBANK_N; k++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank_q[k] <= '0;
      else if (we_i && addr_i == CFG_AW'(k)) bank_q[k] <= unpack_hash(wdata_i);
    end
    assign bank_cfg_o[k] = bank_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      bmask_q <= '0;
    end else if (we_i) begin
      if (addr_i == CFG_AW'(CFG_PC))  pc_q    <= unpack_hash(wdata_i);
      if (addr_i == CFG_AW'(CFG_PCB)) bmask_q <= wdata_i[BANK_W-1:0];
    end
  end

  assign pc_cfg_o   = pc_q;
  assign pc_bmask_o = bmask_q;

  // R10: no write to the pseudo-channel words unless addressed
  a_r10_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == CFG_AW'(CFG_PC) || addr_i == CFG_AW'(CFG_PCB)))
    |=> ($stable(pc_q) && $stable(bmask_q)));
endmodule

// File: rtl/dram_norm_hash.sv
module dram_norm_hash
  import dram_norm_pkg::*;
(
  input  logic [ENC_W-1:0]  enc_i,
  input  hash_cfg_t         bank_cfg_i [HBANK_N],
  input  hash_cfg_t         pc_cfg_i,
  input  logic [BANK_W-1:0] pc_bmask_i,
  output logic [ENC_W-1:0]  fixed_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  logic [COL_W-1:0]   col;
  logic [ROW_W-1:0]   row;
  logic [HBANK_N-1:0] bank_lo;
  logic [BANK_W-1:0]  bank;
  logic               pc;

  assign col = enc_i[COL_LSB +: COL_W];
  assign row = enc_i[ROW_LSB +: ROW_W];

  for (genvar k = 0; k < HBANK_N; k++) begin : g_lane
    assign bank_lo[k] = enc_i[BANK_LSB+k] ^ hash_term(bank_cfg_i[k], col, row);
  end

  assign bank = {enc_i[BHI_LSB +: BANK_W-HBANK_N], bank_lo};
  assign pc   = enc_i[PC_POS] ^ (pc_cfg_i.en &
                (hash_term(pc_cfg_i, col, row) ^ (^(bank & pc_bmask_i))));

  always_comb begin
    fixed_o = enc_i;
    fixed_o[BANK_LSB +: HBANK_N] = bank_lo;
    fixed_o[PC_POS] = pc;
  end

  assign bank_o = bank;
  assign row_o  = row;
  assign col_o  = col;
endmodule

// File: rtl/dram_norm_scatter.sv
module dram_norm_scatter
  import dram_norm_pkg::*;
(
  input  logic [ENC_W-1:0]  fixed_i,
  output logic [NORM_W-1:0] norm_o
);
  always_comb begin
    norm_o = '0;
    for (int i = 1; i <= ENC_W - 2; i++) norm_o[norm_pos(i)] = fixed_i[i];
  end
endmodule

// File: rtl/dram_addr_normalizer.sv
module dram_addr_normalizer
  import dram_norm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              in_valid_i,
  input  logic [27:0]       in_addr_i,
  output logic              out_valid_o,
  output logic [30:0]       out_addr_o,
  output logic [5:0]        out_bank_o,
  output logic [13:0]       out_row_o,
  output logic [4:0]        out_col_o
);
  hash_cfg_t         bank_cfg [HBANK_N];
  hash_cfg_t         pc_cfg;
  logic [BANK_W-1:0] pc_bmask;
  logic [ENC_W-1:0]  fixed;
  logic [BANK_W-1:0] bank_d;
  logic [ROW_W-1:0]  row_d;
  logic [COL_W-1:0]  col_d;
  logic [NORM_W-1:0] norm_d;

  dram_norm_cfg i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .bank_cfg_o(bank_cfg), .pc_cfg_o(pc_cfg), .pc_bmask_o(pc_bmask)
  );

  dram_norm_hash i_hash (
    .enc_i(in_addr_i), .bank_cfg_i(bank_cfg), .pc_cfg_i(pc_cfg),
    .pc_bmask_i(pc_bmask), .fixed_o(fixed), .bank_o(bank_d),
    .row_o(row_d), .col_o(col_d)
  );

  dram_norm_scatter i_scatter (.fixed_i(fixed), .norm_o(norm_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= in_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_addr_o <= '0;
      out_bank_o <= '0;
      out_row_o  <= '0;
      out_col_o  <= '0;
    end else if (in_valid_i) begin
      out_addr_o <= norm_d;
      out_bank_o <= bank_d;
      out_row_o  <= row_d;
      out_col_o  <= col_d;
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r8_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(out_addr_o)));
  a_r7_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_addr_o[4:0] == 5'd0);
  a_r2_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (out_row_o == $past(in_addr_i[23:10]) &&
                    out_col_o == $past(in_addr_i[5:1])));
  a_r4_bank_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (out_bank_o[5:4] == $past(in_addr_i[27:26])));
  a_r6_top_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (out_addr_o[30] == $past(in_addr_i[26]) &&
                    out_addr_o[28] == $past(in_addr_i[23])));
endmodule

// File: tb/test_dram_addr_normalizer.sv
module test_dram_addr_normalizer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [27:0] in_addr = '0;
  logic        out_valid;
  logic [30:0] out_addr;
  logic [5:0]  out_bank;
  logic [13:0] out_row;
  logic [4:0]  out_col;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of hash words
  logic        m_en [5];
  logic [4:0]  m_cm [5];
  logic [13:0] m_rm [5];
  logic [5:0]  m_bm;

  always #2 clk = ~clk;

  dram_addr_normalizer i_dram_addr_normalizer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .in_valid_i(in_valid), .in_addr_i(in_addr),
    .out_valid_o(out_valid), .out_addr_o(out_addr), .out_bank_o(out_bank),
    .out_row_o(out_row), .out_col_o(out_col)
  );

  function automatic int dest(int i);
    int t [27] = '{0, 5, 6, 8, 9, 14, 12, 13, 10, 11, 15, 16, 17, 18, 19, 20,
                   21, 22, 23, 24, 25, 26, 27, 28, 7, 29, 30};
    return t[i];
  endfunction

  function automatic logic hterm(int k, logic [27:0] a);
    return m_en[k] & ((^(a[5:1] & m_cm[k])) ^ (^(a[23:10] & m_rm[k])));
  endfunction

  function automatic logic [5:0] exp_bank(logic [27:0] a);
    logic [5:0] b;
    for (int k = 0; k < 4; k++) b[k] = a[6+k] ^ hterm(k, a);
    b[5:4] = a[27:26];
    return b;
  endfunction

  function automatic logic [30:0] exp_norm(logic [27:0] a);
    logic [27:0] f = a;
    logic [5:0]  b = exp_bank(a);
    logic [30:0] n = '0;
    f[9:6] = b[3:0];
    f[25]  = a[25] ^ (m_en[4] & (hterm(4, a) ^ (^(b & m_bm))));
    for (int i = 1; i <= 26; i++) n[dest(i)] = f[i];
    return n;
  endfunction

  function automatic void model_wr(logic [2:0] a, logic [31:0] d);
    if (a <= 3'd4) begin
      m_en[a] = d[0];
      m_cm[a] = d[5:1];
      m_rm[a] = d[27:14];
    end else if (a == 3'd5) m_bm = d[5:0];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // one conversion, optional write in the same cycle
  task automatic conv(logic [27:0] a, bit wr, logic [2:0] wa, logic [31:0] wd,
                      string req);
    logic [30:0] en;
    logic [5:0]  eb;
    @(negedge clk);
    en = exp_norm(a);
    eb = exp_bank(a);
    in_valid = 1'b1;
    in_addr  = a;
    cfg_we   = wr;
    cfg_addr = wa;
    cfg_wdata = wd;
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we   = 1'b0;
    if (wr) void'(model_wr(wa, wd));
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " addr"}, 64'(out_addr), 64'(en));
    chk({req, " bank"}, 64'(out_bank), 64'(eb));
    chk({req, " row"}, 64'(out_row), 64'(a[23:10]));
    chk({req, " col"}, 64'(out_col), 64'(a[5:1]));
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    void'(model_wr(a, d));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [30:0] held;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 5; k++) begin m_en[k] = 0; m_cm[k] = 0; m_rm[k] = 0; end
    m_bm = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid at reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle valid", 64'(out_valid), 64'd0);

    // R1/R6: no hashing after reset -> plain permutation
    conv(28'h0000002, 0, 0, 0, "R6 bit1");
    chk("R6 bit1 pos5", 64'(out_addr), 64'h20);
    conv(28'h1000000, 0, 0, 0, "R6 bit24");
    chk("R6 bit24 pos7", 64'(out_addr), 64'h80);
    conv(28'h0000020, 0, 0, 0, "R6 bit5");
    chk("R6 bit5 pos14", 64'(out_addr), 64'h4000);
    conv(28'hFFFFFFF, 0, 0, 0, "R1 R7 all ones");
    chk("R7 all ones", 64'(out_addr), 64'h7FFFFFE0);
    conv(28'h8000001, 0, 0, 0, "R7 dropped bits");
    chk("R7 drop 0 and 27", 64'(out_addr), 64'h0);
    chk("R4 bank5 from bit27", 64'(out_bank), 64'h20);
    held = out_addr;
    @(negedge clk);
    chk("R8 one cycle valid", 64'(out_valid), 64'd0);
    chk("R8 hold data", 64'(out_addr), 64'(held));

    // R3: bank hash lane 2, column mask bit 0 enabled
    wr(3'd2, 32'h0000_0003);
    conv(28'h0000002, 0, 0, 0, "R3 lane2 col");
    chk("R3 bank2 flip", 64'(out_bank), 64'h04);
    // R10: writes to unused addresses
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    conv(28'h0000000, 0, 0, 0, "R10 ignored");
    chk("R10 zero in zero out", 64'(out_addr), 64'h0);

    // R5: pc hash driven only by bank mask on bank bit 5
    wr(3'd4, 32'h0000_0001);
    wr(3'd5, 32'hFFFF_FF20);
    conv(28'h8000000, 0, 0, 0, "R5 bank mask");
    chk("R5 pc from bit27", 64'(out_addr), 64'h2000_0000);

    // R9: write coinciding with input; old words apply
    conv(28'h0000400, 1, 3'd0, 32'h0000_4001, "R9 same cycle");
    chk("R9 bank0 unchanged", 64'(out_bank[0]), 64'd0);
    conv(28'h0000400, 0, 0, 0, "R9 next input");
    chk("R9 bank0 flipped", 64'(out_bank[0]), 64'd1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [27:0] a = 28'($urandom);
      bit w = ($urandom % 3) == 0;
      logic [2:0] wa = 3'($urandom);
      logic [31:0] wd = $urandom;
      conv(a, w, wa, wd, w ? "R9 R3 R5 random" : "R3 R4 R6 random");
      if ((n % 16) == 0) begin
        @(negedge clk);
        chk("R8 random idle", 64'(out_valid), 64'd0);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule